// File: doc/BRIEF.md
# Pulse-Width Threshold Discriminator

The block tells whether each pulse on a slow, periodic PWM line (such as a 50 Hz servo-style signal with a 20 ms frame) is wider than a fixed threshold. The default threshold is 1500 µs, which at a 10 MHz system clock is 15000 cycles. The raw line first passes through a synchronizer. A rising edge of the synchronized level then starts a fixed-length timing window. When the window closes, the block takes one sample of the synchronized level. A level that is still high means the pulse is wider than the threshold.

That one sample is loaded into a registered decision bit. The decision bit holds its value for the rest of the frame, until the next sample replaces it. A valid strobe marks each new decision for one cycle. The window has a fixed length and is started by the edge alone. It is never stretched by an input that stays high. A rising edge that arrives while the window is open does not restart it.

Reset is asynchronous and active low, and its release is synchronized to the clock.

Top module: `pwm_width_discriminator`

## Requirements
- R1: While reset is asserted, and after it is released, `width_long_o` and `decide_vld_o` are 0. No strobe occurs until a rising edge is seen on the input.
- R2: The window starts on a rising edge of the synchronized input, which is delayed by SYNC_STAGES flops. `decide_vld_o` is high after exactly THRESH_CYCLES+SYNC_STAGES+1 rising clock edges, counted from the first edge that sees `pwm_raw_i` high.
- R3: A pulse that stays high for more than THRESH_CYCLES clock cycles gives `width_long_o` = 1 at the strobe.
- R4: A pulse that stays high for THRESH_CYCLES cycles or fewer gives `width_long_o` = 0 at the strobe. A pulse of exactly THRESH_CYCLES cycles counts as not longer.
- R5: The sample time does not depend on the pulse width. A pulse that is still high when the window closes produces its strobe at the same latency as a short one.
- R6: A rising edge that arrives while the window is open is ignored. The window is not restarted, and the frame yields exactly one strobe.
- R7: `decide_vld_o` is high for exactly one cycle per decision.
- R8: `width_long_o` changes only together with a strobe. Between strobes it holds the previous decision for the whole frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock (about 10 MHz for the default threshold) |
| rst_ni | input | 1 | Asynchronous active-low reset; its release is synchronized inside |
| pwm_raw_i | input | 1 | Raw, asynchronous PWM line |
| width_long_o | output | 1 | Registered decision: 1 means the last pulse was wider than the threshold |
| decide_vld_o | output | 1 | One-cycle strobe marking a new decision |

## Verification
The bench builds the block with THRESH_CYCLES = 40 and keeps the default of two synchronizer stages. A 200-cycle frame can then hold pulses on both sides of the threshold, including widths of 39, 40, 41 and 43 cycles. It can also hold a pulse that is still high long after the window closes, and a second edge that arrives inside the open window.

With a threshold this short, the exact strobe latency of 43 edges can be checked in every frame. Holding of the decision can be checked cycle by cycle across the whole frame, and a reset applied in the middle of a window stays affordable.

// File: rtl/pwd_pkg.sv
package pwd_pkg;

  typedef enum logic {
    WIN_IDLE = 1'b0,
    WIN_RUN  = 1'b1
  } win_state_e;

  function automatic int cnt_bits(input int limit);
    return $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/pwd_rst_sync.sv
module pwd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] chain_q;

  // assert immediately, release after STAGES clock edges
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_no = chain_q[STAGES-1];

endmodule

// File: rtl/pwd_in_sync.sv
module pwd_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic level_o,
  output logic rise_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;

  // shift chain built stage by stage
  assign sync_d[0] = raw_i;
  for (genvar g = 1; g < STAGES; g++) begin : g_chain
    assign sync_d[g] = sync_q[g-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign level_o = sync_q[STAGES-1];
  assign rise_o  = level_o & ~prev_q;

  // a rise is always followed by a level that was seen high one cycle earlier
  assert_rise_prev_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> prev_q);

endmodule

// File: rtl/pwd_window_timer.sv
module pwd_window_timer
  import pwd_pkg::*;
#(
  parameter int THRESH_CYCLES = 15000,
  parameter int CNT_W         = cnt_bits(THRESH_CYCLES)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rise_i,
  output logic sample_o,
  output logic busy_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(THRESH_CYCLES);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  win_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             at_last;

  assign at_last = (cnt_q == LAST);

  // next-state logic
  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    sample_o = 1'b0;
    unique case (state_q)
      WIN_IDLE: begin
        if (rise_i) begin
          state_d = WIN_RUN;
          cnt_d   = ONE;
        end
      end
      WIN_RUN: begin
        if (at_last) begin
          sample_o = 1'b1;
          state_d  = WIN_IDLE;
          cnt_d    = '0;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end
      default: begin
        state_d = WIN_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  assign cnt_en = (state_q == WIN_RUN) || rise_i;
  assign busy_o = (state_q == WIN_RUN);

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WIN_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assert_cnt_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);

  assert_idle_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == WIN_IDLE) |-> (cnt_q == '0));

  assert_retrig_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == WIN_RUN) && !at_last && rise_i) |=>
      ((state_q == WIN_RUN) && (cnt_q == $past(cnt_q) + ONE)));

  assert_window_ends_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == WIN_RUN) && at_last) |=> (state_q == WIN_IDLE));

endmodule

// File: rtl/pwd_decision.sv
module pwd_decision (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sample_i,
  input  logic level_i,
  output logic long_o,
  output logic vld_o
);

  logic long_q, long_d;
  logic vld_q;

  assign long_d = level_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      long_q <= 1'b0;
    end else if (sample_i) begin
      long_q <= long_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= sample_i;
    end
  end

  assign long_o = long_q;
  assign vld_o  = vld_q;

  assert_strobe_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |=> !vld_q);

endmodule

// File: rtl/pwm_width_discriminator.sv
module pwm_width_discriminator
  import pwd_pkg::*;
#(
  parameter int THRESH_CYCLES = 15000,
  parameter int SYNC_STAGES   = 2,
  parameter int RST_STAGES    = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwm_raw_i,
  output logic width_long_o,
  output logic decide_vld_o
);

  localparam int CNT_W = cnt_bits(THRESH_CYCLES);

  logic rst_n;
  logic level;
  logic rise;
  logic sample;
  logic busy;

  pwd_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n)
  );

  pwd_in_sync #(.STAGES(SYNC_STAGES)) u_in_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .raw_i   (pwm_raw_i),
    .level_o (level),
    .rise_o  (rise)
  );

  pwd_window_timer #(
    .THRESH_CYCLES (THRESH_CYCLES),
    .CNT_W         (CNT_W)
  ) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .rise_i   (rise),
    .sample_o (sample),
    .busy_o   (busy)
  );

  pwd_decision u_decision (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .sample_i (sample),
    .level_i  (level),
    .long_o   (width_long_o),
    .vld_o    (decide_vld_o)
  );

  assert_sample_level_R3: assert property (@(posedge clk_i) disable iff (!rst_n)
    sample |=> (decide_vld_o && (width_long_o == $past(level))));

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    !decide_vld_o |-> $stable(width_long_o));

  assert_start_on_edge_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(busy) |-> $past(rise));

  assert_reset_low_R1: assert property (@(posedge clk_i)
    !rst_n |-> (!width_long_o && !decide_vld_o));

endmodule

// File: tb/pwm_width_discriminator_bench.sv
module pwm_width_discriminator_bench;

  localparam int CLK_PERIOD = 100;
  localparam int THRESH     = 40;
  localparam int LATENCY    = THRESH + 3;
  localparam int FRAME      = 200;
  localparam int NVEC       = 8;
  localparam int VEC_W   [NVEC] = '{5, 39, 40, 41, 43, 150, 10, 100};
  localparam bit VEC_EXP [NVEC] = '{0, 0,  0,  1,  1,  1,   0,  1};

  logic clk;
  logic rst_n;
  logic raw;
  logic long_o;
  logic vld_o;

  int n_cmp;
  int n_bad;
  bit prev_dec;

  pwm_width_discriminator #(.THRESH_CYCLES(THRESH)) u_pwm_width_discriminator (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .pwm_raw_i    (raw),
    .width_long_o (long_o),
    .decide_vld_o (vld_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one frame: raise at a negedge, drop after w steps; a second pulse may follow
  task automatic run_frame(input int w, input int w2_at, input int w2_len, input bit exp,
                           input string req);
    int first_at;
    int strobes;
    bit hold_ok;
    bit pre_ok;
    first_at = -1;
    strobes  = 0;
    hold_ok  = 1'b1;
    pre_ok   = 1'b1;
    raw = 1'b1;
    for (int i = 1; i <= FRAME; i++) begin
      @(negedge clk);
      if (i == w) raw = 1'b0;
      if (w2_at > 0 && i == w2_at) raw = 1'b1;
      if (w2_at > 0 && i == w2_at + w2_len) raw = 1'b0;
      if (vld_o) begin
        strobes++;
        if (first_at < 0) begin
          first_at = i;
          chk(long_o == exp, req, long_o, exp);
        end
      end else if (first_at < 0) begin
        if (long_o != prev_dec) pre_ok = 1'b0;
      end else if (long_o != exp) begin
        hold_ok = 1'b0;
      end
    end
    raw = 1'b0;
    chk(first_at == LATENCY, "R2/R5 latency", first_at, LATENCY);
    chk(strobes == 1, "R7/R6 strobe count", strobes, 1);
    chk(pre_ok, "R8 hold before strobe", pre_ok, 1);
    chk(hold_ok, "R8 hold after strobe", hold_ok, 1);
    prev_dec = exp;
  endtask

  initial begin
    int seen;
    n_cmp    = 0;
    n_bad    = 0;
    prev_dec = 1'b0;
    raw      = 1'b0;
    rst_n    = 1'b0;
    repeat (3) @(negedge clk);
    chk(long_o == 1'b0 && vld_o == 1'b0, "R1 in reset", {long_o, vld_o}, 0);
    rst_n = 1'b1;
    seen = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (vld_o || long_o) seen++;
    end
    chk(seen == 0, "R1 quiet after reset", seen, 0);

    // table of widths and expected decisions (R3 above threshold, R4 at or below)
    for (int v = 0; v < NVEC; v++) begin
      run_frame(VEC_W[v], 0, 0, VEC_EXP[v], VEC_EXP[v] ? "R3" : "R4");
    end

    // R6: second rise at step 15, inside the open window, high through the sample
    run_frame(10, 15, 30, 1'b1, "R6");

    // R4 exact threshold after a long decision: falls back to 0
    run_frame(THRESH, 0, 0, 1'b0, "R4 exact");

    // R1: reset in the middle of a window after a long decision
    run_frame(100, 0, 0, 1'b1, "R3");
    raw = 1'b1;
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(long_o == 1'b0 && vld_o == 1'b0, "R1 mid-window reset", {long_o, vld_o}, 0);
    raw = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    seen = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (vld_o || long_o) seen++;
    end
    chk(seen == 0, "R1 window abandoned", seen, 0);
    prev_dec = 1'b0;
    run_frame(60, 0, 0, 1'b1, "R3 after reset");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule